// File: doc/BRIEF.md
# Cartridge DMA Register Front End

This block is the software-visible register bank that sits in front of a cartridge-bus DMA copy engine. A 32-bit register bus with a per-bit write mask reaches thirteen word registers. These are the system-memory address, the cartridge address, two transfer lengths, a status word, and two groups of four 8-bit bus-timing values, one group per cartridge domain. Every stored register takes a masked merge. Bits selected by the mask take the new data, and all other bits keep their old value.

Writing a length register launches a transfer. The register written picks the direction. The read-length register moves data from memory to the cartridge. The write-length register moves data from the cartridge to memory. The block raises a one-cycle start pulse and sets its busy flag. It then holds busy until the engine returns a done pulse. Done clears busy and raises a level interrupt, which stays high until software clears it through the status register. A length write that arrives while a transfer is running is dropped entirely.

Top module: `cbus_dma_regs`

## Requirements
- R1: After reset, every readable register returns 0, and `irq`, `eng_start` and busy are low.
- R2: Index 0 (memory address) and index 1 (cartridge address) store `(old & ~mask) | (data & mask)` over all 32 bits. They appear on `eng_mem_addr` and `eng_cart_addr`.
- R3: Indices 5 to 8 (domain one) and 9 to 12 (domain two) hold timing values. Each one merges under the mask and then keeps only bits 7:0. A read of a timing value returns zero in bits 31:8.
- R4: An accepted write to index 2 merges the read length. One cycle later, `eng_start` is high for exactly one cycle, with `eng_to_mem` = 0 and `eng_len` equal to the merged value. Busy is set from that same edge onward.
- R5: An accepted write to index 3 merges the write length and gives the same start pulse as R4, but with `eng_to_mem` = 1.
- R6: A length write while busy is ignored. The stored length is unchanged and no start pulse follows.
- R7: An `eng_done` pulse clears busy and sets `irq`. `irq` then stays high until it is cleared.
- R8: A write to index 4 stores nothing. It clears `irq` only when bit 1 is set in both data and mask. Bit 0 and all other bits have no effect. A status read returns busy in bit 0 and interrupt pending in bit 3, with zeros elsewhere.
- R9: When `eng_done` and a clearing status write fall in the same cycle, `irq` ends up high.
- R10: Indices 13 to 15 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 4 | Word index (byte offset divided by four) |
| reg_wdata | input | 32 | Write data |
| reg_wmask | input | 32 | Per-bit write mask |
| reg_rdata | output | 32 | Read data for `reg_idx`, combinational |
| eng_start | output | 1 | One-cycle transfer launch |
| eng_to_mem | output | 1 | 1 = cartridge to memory, 0 = memory to cartridge |
| eng_mem_addr | output | 32 | Memory address register |
| eng_cart_addr | output | 32 | Cartridge address register |
| eng_len | output | 32 | Length register for the current direction |
| eng_done | input | 1 | Transfer-complete pulse from the engine |
| irq | output | 1 | Interrupt level |

## Verification
The bench drives the masked merge three ways. A full mask checks plain storage. A partial mask separates a correct merge from a plain overwrite. Data wider than 8 bits on the timing values catches a missing truncation. Launches are tried in both directions and again while busy, which tells an ignored write apart from a restart or a silent store. The interrupt is exercised with a reset-only status write, with a clear that is masked off, with a real clear, and with done and clear in the same cycle, which pins down the priority.

// File: rtl/cbus_dma_regs.sv
module cbus_dma_regs #(
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 4,
  parameter int TIM_W       = 8,
  parameter int NUM_DOM     = 2,
  parameter int TIM_PER_DOM = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_wmask,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              eng_start,
  output logic              eng_to_mem,
  output logic [DATA_W-1:0] eng_mem_addr,
  output logic [DATA_W-1:0] eng_cart_addr,
  output logic [DATA_W-1:0] eng_len,
  input  logic              eng_done,
  output logic              irq
);
  localparam int NUM_TIM   = NUM_DOM * TIM_PER_DOM;
  localparam int TSEL_W    = (NUM_TIM > 1) ? $clog2(NUM_TIM) : 1;
  localparam int IX_MEM    = 0;
  localparam int IX_CART   = 1;
  localparam int IX_RDLEN  = 2;
  localparam int IX_WRLEN  = 3;
  localparam int IX_STAT   = 4;
  localparam int IX_TIM    = 5;
  localparam int ST_BUSY   = 0;
  localparam int ST_IRQ    = 3;
  localparam int WR_CLR    = 1;

  logic [DATA_W-1:0] mem_q, cart_q, rdlen_q, wrlen_q;
  logic [TIM_W-1:0]  tim_q [NUM_TIM];
  logic              busy_q;

  logic [DATA_W-1:0] merged;
  assign merged = (reg_wdata & reg_wmask);

  function automatic logic [DATA_W-1:0] mrg(input logic [DATA_W-1:0] old);
    return (old & ~reg_wmask) | merged;
  endfunction

  logic hit_rd, hit_wr, accept, clr_req;
  assign hit_rd  = reg_wr && (reg_idx == IDX_W'(IX_RDLEN));
  assign hit_wr  = reg_wr && (reg_idx == IDX_W'(IX_WRLEN));
  assign accept  = (hit_rd || hit_wr) && !busy_q;
  assign clr_req = reg_wr && (reg_idx == IDX_W'(IX_STAT)) && merged[WR_CLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q   <= '0;
      cart_q  <= '0;
      rdlen_q <= '0;
      wrlen_q <= '0;
    end else if (reg_wr) begin
      if (reg_idx == IDX_W'(IX_MEM))  mem_q  <= mrg(mem_q);
      if (reg_idx == IDX_W'(IX_CART)) cart_q <= mrg(cart_q);
      if (hit_rd && !busy_q)          rdlen_q <= mrg(rdlen_q);
      if (hit_wr && !busy_q)          wrlen_q <= mrg(wrlen_q);
    end
  end

  for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim
    logic [DATA_W-1:0] nxt;
    assign nxt = mrg({{(DATA_W-TIM_W){1'b0}}, tim_q[g]});
    always_ff @(posedge clk) begin
      if (!rst_n) tim_q[g] <= '0;
      else if (reg_wr && reg_idx == IDX_W'(IX_TIM + g)) tim_q[g] <= nxt[TIM_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      irq        <= 1'b0;
      eng_start  <= 1'b0;
      eng_to_mem <= 1'b0;
    end else begin
      eng_start <= accept;
      if (accept) eng_to_mem <= hit_wr;
      if (accept)        busy_q <= 1'b1;
      else if (eng_done) busy_q <= 1'b0;
      if (eng_done)      irq <= 1'b1;
      else if (clr_req)  irq <= 1'b0;
    end
  end

  assign eng_mem_addr  = mem_q;
  assign eng_cart_addr = cart_q;
  assign eng_len       = eng_to_mem ? wrlen_q : rdlen_q;

  logic [IDX_W-1:0]  tim_off;
  logic [TSEL_W-1:0] tsel;
  assign tim_off = reg_idx - IDX_W'(IX_TIM);
  assign tsel    = tim_off[TSEL_W-1:0];

  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      IDX_W'(IX_MEM):   reg_rdata = mem_q;
      IDX_W'(IX_CART):  reg_rdata = cart_q;
      IDX_W'(IX_RDLEN): reg_rdata = rdlen_q;
      IDX_W'(IX_WRLEN): reg_rdata = wrlen_q;
      IDX_W'(IX_STAT): begin
        reg_rdata[ST_BUSY] = busy_q;
        reg_rdata[ST_IRQ]  = irq;
      end
      default:
        if (reg_idx >= IDX_W'(IX_TIM) && reg_idx < IDX_W'(IX_TIM + NUM_TIM))
          reg_rdata[TIM_W-1:0] = tim_q[tsel];
    endcase
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!irq && !eng_start)); // R1
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R4
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_start) |-> $past(!busy_q)); // R5
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && reg_wr && (reg_idx == IDX_W'(IX_RDLEN))) |=> (!eng_start && $stable(rdlen_q))); // R6
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> (irq && !busy_q)); // R7
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_req) |=> irq); // R8
  AST_TIM_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx >= IDX_W'(IX_TIM)) |-> (reg_rdata[DATA_W-1:TIM_W] == '0)); // R3
endmodule

// File: tb/cbus_dma_regs_tb.sv
module cbus_dma_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_idx = '0;
  logic [31:0] reg_wdata = '0, reg_wmask = '0;
  logic [31:0] reg_rdata, eng_mem_addr, eng_cart_addr, eng_len;
  logic eng_start, eng_to_mem, irq;
  logic eng_done = 1'b0;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  cbus_dma_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .reg_rdata(reg_rdata),
    .eng_start(eng_start), .eng_to_mem(eng_to_mem), .eng_mem_addr(eng_mem_addr),
    .eng_cart_addr(eng_cart_addr), .eng_len(eng_len), .eng_done(eng_done), .irq(irq)
  );

  // behavioural reference
  logic [31:0] m_reg [16];
  logic m_busy = 0, m_irq = 0, m_start = 0, m_dir = 0;

  function automatic logic [31:0] mg(input logic [31:0] o);
    return (o & ~reg_wmask) | (reg_wdata & reg_wmask);
  endfunction

  function automatic logic [31:0] m_read(input int i);
    if (i == 4) return {28'd0, m_irq, 2'b00, m_busy};
    if (i >= 13) return 32'd0;
    return m_reg[i];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_reg[i] = 0;
      m_busy = 0; m_irq = 0; m_start = 0; m_dir = 0;
    end else begin
      bit acc, clr;
      acc = 0; clr = 0;
      if (reg_wr) begin
        if (reg_idx <= 1) m_reg[reg_idx] = mg(m_reg[reg_idx]);
        else if (reg_idx <= 3) begin
          if (!m_busy) begin
            m_reg[reg_idx] = mg(m_reg[reg_idx]);
            acc = 1;
            m_dir = (reg_idx == 3);
          end
        end else if (reg_idx == 4) clr = reg_wdata[1] & reg_wmask[1];
        else if (reg_idx <= 12) m_reg[reg_idx] = mg(m_reg[reg_idx]) & 32'hFF;
      end
      m_start = acc;
      if (acc) m_busy = 1; else if (eng_done) m_busy = 0;
      if (eng_done) m_irq = 1; else if (clr) m_irq = 0;
    end
    cyc++;
  end

  // per-cycle comparison (R2 R3 R4 R5 R7 R8)
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      logic [31:0] e_len;
      e_len = m_dir ? m_reg[3] : m_reg[2];
      n_cmp++;
      if (eng_start !== m_start || eng_to_mem !== m_dir || irq !== m_irq ||
          eng_mem_addr !== m_reg[0] || eng_cart_addr !== m_reg[1] ||
          eng_len !== e_len || reg_rdata !== m_read(reg_idx)) begin
        n_bad++;
        $display("FAIL cycle model (R2 R4 R7) cyc=%0d act st=%b dir=%b irq=%b len=%h rd=%h exp st=%b dir=%b irq=%b len=%h rd=%h",
          cyc, eng_start, eng_to_mem, irq, eng_len, reg_rdata, m_start, m_dir, m_irq, e_len, m_read(reg_idx));
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    reg_wr = 1; reg_idx = 4'(i); reg_wdata = d; reg_wmask = m;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0; reg_wmask = 0;
  endtask

  task automatic rd(input int i, output logic [31:0] v);
    @(negedge clk);
    reg_idx = 4'(i);
    #1 v = reg_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 16; i++) begin rd(i, v); chk("R1 reset read", v, 0); end
    chk("R1 reset irq", {31'd0, irq}, 0);
    chk("R1 reset start", {31'd0, eng_start}, 0);

    wr(0, 32'h1234_5678, 32'hFFFF_FFFF);
    wr(0, 32'hAAAA_BBBB, 32'h0000_FFFF);
    rd(0, v); chk("R2 mem partial merge", v, 32'h1234_BBBB);
    wr(1, 32'hF0F0_F0F0, 32'hFF00_FF00);
    rd(1, v); chk("R2 cart merge", v, 32'hF000_F000);
    chk("R2 cart port", eng_cart_addr, 32'hF000_F000);

    wr(5, 32'hFFFF_FF5A, 32'hFFFF_FFFF);
    rd(5, v); chk("R3 timing truncate", v, 32'h0000_005A);
    wr(12, 32'h0000_0003, 32'h0000_000F);
    rd(12, v); chk("R3 timing masked", v, 32'h0000_0003);
    wr(9, 32'h0000_01C7, 32'h0000_01F0);
    rd(9, v); chk("R3 timing second domain", v, 32'h0000_00C0);

    @(negedge clk);
    reg_wr = 1; reg_idx = 2; reg_wdata = 32'h100; reg_wmask = 32'hFFFF_FFFF;
    @(negedge clk);
    reg_wr = 0;
    #1;
    chk("R4 start pulse", {31'd0, eng_start}, 1);
    chk("R4 direction", {31'd0, eng_to_mem}, 0);
    chk("R4 length", eng_len, 32'h100);
    @(negedge clk); #1;
    chk("R4 single cycle", {31'd0, eng_start}, 0);
    rd(4, v); chk("R4 busy in status", v, 32'h1);

    wr(3, 32'h77, 32'hFFFF_FFFF);
    chk("R6 no start while busy", {31'd0, eng_start}, 0);
    rd(3, v); chk("R6 length not stored", v, 0);
    wr(2, 32'h999, 32'hFFFF_FFFF);
    rd(2, v); chk("R6 rdlen kept", v, 32'h100);

    pulse_done();
    rd(4, v); chk("R7 status after done", v, 32'h8);
    repeat (4) @(negedge clk);
    chk("R7 irq held", {31'd0, irq}, 1);

    wr(4, 32'h1, 32'hFFFF_FFFF);
    rd(4, v); chk("R8 reset bit ignored", v, 32'h8);
    wr(4, 32'h2, 32'h0);
    chk("R8 masked clear ignored", {31'd0, irq}, 1);
    wr(4, 32'hFFFF_FFFF, 32'h2);
    rd(4, v); chk("R8 clear", v, 0);

    @(negedge clk);
    reg_wr = 1; reg_idx = 3; reg_wdata = 32'h40; reg_wmask = 32'hFFFF_FFFF;
    @(negedge clk);
    reg_wr = 0;
    #1;
    chk("R5 start pulse", {31'd0, eng_start}, 1);
    chk("R5 direction", {31'd0, eng_to_mem}, 1);
    chk("R5 length", eng_len, 32'h40);

    @(negedge clk);
    reg_wr = 1; reg_idx = 4; reg_wdata = 32'h2; reg_wmask = 32'h2; eng_done = 1;
    @(negedge clk);
    reg_wr = 0; eng_done = 0;
    #1 chk("R9 done beats clear", {31'd0, irq}, 1);
    rd(4, v); chk("R9 status", v, 32'h8);
    wr(4, 32'h2, 32'h2);
    chk("R8 clear after priority", {31'd0, irq}, 0);

    for (int i = 13; i < 16; i++) begin
      wr(i, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      rd(i, v); chk("R10 unmapped reads zero", v, 0);
    end
    rd(0, v); chk("R10 mem untouched", v, 32'h1234_BBBB);
    rd(5, v); chk("R10 timing untouched", v, 32'h5A);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule